// File: doc/BRIEF.md
# Two-Bank SDRAM Command Timing Gate

This block sits beside an SDRAM command scheduler and judges, on every clock, whether the command the scheduler wants to issue this cycle would break any bank timing rule. It follows the two banks of the device through idle, open and closing phases. For each bank it counts the cycles since the row was opened, since the bank was closed, and since the last write data beat. It also counts the cycles since the most recent row open on either bank. The timing limits are cycle counts that arrive as inputs, so firmware can set them from the clock period. A count of zero is treated as one cycle.

A request is answered in the same cycle. Either `grant` is high and the command may go to the device on this edge, or `stall` is high and the scheduler must hold the command and try again. A request is never dropped. For each bank the block also reports whether it is idle and whether it is open. It raises a warning when an open row nears its longest allowed open time, and an overdue flag once that time has passed. Reset leaves both banks idle, with every timer already past its limit.

Top module: `bank_cmd_gate`

## Requirements
- R1: An open-row command (code 1) is granted only when the addressed bank is idle. One cycle after the grant, that bank reads open (`bank_active` high, `bank_idle` low).
- R2: A read (code 2) or write (code 3) is granted only when the addressed bank is open and at least max(tRCD,1) cycles have passed since its open-row grant.
- R3: An open-row command to the bank other than the one opened most recently is granted only when at least max(tRRD,1) cycles have passed since the previous open-row grant.
- R4: A close command (code 4) is granted only when the addressed bank is open and at least max(tRAS_min,1) cycles have passed since its open-row grant.
- R5: While a bank is open, `pchg_warn` is high once (cycles since open + WARN_LEAD) ≥ max(tRAS_max,1), and `pchg_late` is high once the cycles since open exceed max(tRAS_max,1). Both flags are low while the bank is not open.
- R6: After a close granted in cycle t, the bank is neither open nor idle until cycle t+max(tRP,1), when it reads idle.
- R7: Refresh (code 5), mode set (code 6) and power-down (code 7) are granted only when both banks are idle.
- R8: A close to a bank is stalled in any cycle that carries that bank's last write data beat, and until max(tRDL,1) cycles have passed since that beat.
- R9: A programmed count of zero acts exactly like a count of one.
- R10: With `req_valid` high, exactly one of `grant` and `stall` is high. With it low, both are low. Code 0 (no operation) is always granted.
- R11: After reset both banks are idle and not open, no warning or overdue flag is set, and every command the rules allow in an idle state is granted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A command is requested this cycle |
| req_cmd | input | 3 | Command code (0 nop, 1 open row, 2 read, 3 write, 4 close, 5 refresh, 6 mode set, 7 power-down) |
| req_bank | input | 1 | Addressed bank |
| wr_last | input | 1 | The last data beat of a write burst is on the bus this cycle |
| wr_last_bank | input | 1 | Bank of that last write beat |
| cfg_trcd | input | CNT_W | Open-to-access cycles |
| cfg_trrd | input | CNT_W | Open-to-open spacing across banks |
| cfg_tras_min | input | CNT_W | Shortest open time before close |
| cfg_tras_max | input | CNT_W | Longest allowed open time |
| cfg_trp | input | CNT_W | Close-to-idle cycles |
| cfg_trdl | input | CNT_W | Last-write-to-close cycles |
| grant | output | 1 | Request may be issued this cycle |
| stall | output | 1 | Request must be held |
| bank_idle | output | 2 | Per-bank idle flag |
| bank_active | output | 2 | Per-bank open flag |
| pchg_warn | output | 2 | Per-bank close-soon warning |
| pchg_late | output | 2 | Per-bank open time exceeded |

## Verification
The bench builds the block with CNT_W = 5 and WARN_LEAD = 3. With these values the age counters saturate at 63, and a longest-open limit of a few cycles crosses both the warning and the overdue thresholds within a short run. Directed sequences run first with small limits and then with all limits at zero. Long random streams follow under several limit sets, so that back-to-back opens across banks, reads at the exact tRCD edge, and closes that race a last write beat all occur many times.

// File: rtl/bank_cmd_pkg.sv
// Package: shared command codes and bank phase encoding for the
// two-bank command timing gate. Assumes a 3-bit command field.
package bank_cmd_pkg;

    localparam int NUM_BANKS = 2;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_OPEN  = 3'd1,
        CMD_READ  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_CLOSE = 3'd4,
        CMD_REFR  = 3'd5,
        CMD_MSET  = 3'd6,
        CMD_PDOWN = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_OPEN    = 2'd1,
        PH_CLOSING = 2'd2
    } phase_e;

endpackage

// File: rtl/bank_track.sv
// Module: per-bank phase and timer tracker.
// Holds the bank phase, one age counter shared by the open and closing
// windows, and an age counter for the last write beat. Both counters
// saturate and leave reset saturated, i.e. expired. Assumes the parent
// only pulses open_go on an idle bank and close_go on an open bank.
module bank_track #(
    parameter int CNT_W     = 8,
    parameter int WARN_LEAD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_go,
    input  logic             close_go,
    input  logic             wbeat_last,
    input  logic [CNT_W-1:0] lim_rcd,
    input  logic [CNT_W-1:0] lim_ras_min,
    input  logic [CNT_W-1:0] lim_ras_max,
    input  logic [CNT_W-1:0] lim_rp,
    input  logic [CNT_W-1:0] lim_rdl,
    output logic             is_idle,
    output logic             is_open,
    output logic             access_ok,
    output logic             close_ok,
    output logic             warn,
    output logic             late
);
    import bank_cmd_pkg::*;

    localparam int AGE_W = CNT_W + 1;
    localparam int SUM_W = AGE_W + 1;
    localparam logic [AGE_W-1:0] AGE_SAT = {AGE_W{1'b1}};
    localparam logic [SUM_W-1:0] LEAD_V  = SUM_W'(WARN_LEAD);

    // Widen a programmed count, mapping zero to one.
    function automatic logic [AGE_W-1:0] eff(input logic [CNT_W-1:0] v);
        logic [AGE_W-1:0] w;
        w = {1'b0, v};
        return (v == '0) ? AGE_W'(1) : w;
    endfunction

    phase_e           phase_q;
    logic [AGE_W-1:0] age_q;
    logic [AGE_W-1:0] wage_q;
    logic [AGE_W-1:0] e_rcd, e_rmin, e_rmax, e_rp, e_rdl;
    logic [SUM_W-1:0] age_plus_lead;

    // Effective limits after the zero-means-one mapping.
    always_comb begin
        e_rcd  = eff(lim_rcd);
        e_rmin = eff(lim_ras_min);
        e_rmax = eff(lim_ras_max);
        e_rp   = eff(lim_rp);
        e_rdl  = eff(lim_rdl);
    end

    // Bank phase: open on grant, closing on close grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else if (open_go) begin
            phase_q <= PH_OPEN;
        end else if (close_go) begin
            phase_q <= PH_CLOSING;
        end
    end

    // Age since the last open or close grant, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= AGE_SAT;
        end else if (open_go || close_go) begin
            age_q <= AGE_W'(1);
        end else if (age_q != AGE_SAT) begin
            age_q <= age_q + AGE_W'(1);
        end
    end

    // Age since the last write beat, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wage_q <= AGE_SAT;
        end else if (wbeat_last) begin
            wage_q <= AGE_W'(1);
        end else if (wage_q != AGE_SAT) begin
            wage_q <= wage_q + AGE_W'(1);
        end
    end

    // Status and permission decode from phase and ages.
    always_comb begin
        age_plus_lead = {1'b0, age_q} + LEAD_V;
        is_open   = (phase_q == PH_OPEN);
        is_idle   = (phase_q == PH_IDLE) ||
                    ((phase_q == PH_CLOSING) && (age_q >= e_rp));
        access_ok = is_open && (age_q >= e_rcd);
        close_ok  = is_open && (age_q >= e_rmin) && !wbeat_last &&
                    (wage_q >= e_rdl);
        warn      = is_open && (age_plus_lead >= {1'b0, e_rmax});
        late      = is_open && (age_q > e_rmax);
    end

endmodule

// File: rtl/open_spacing.sv
// Module: cross-bank open spacing tracker.
// Remembers which bank was opened last and the cycles since that open.
// An open to the other bank is allowed only once the spacing has passed.
// The gap counter leaves reset saturated, so the first open is free.
module open_spacing #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_go,
    input  logic             open_bank,
    input  logic             ask_bank,
    input  logic [CNT_W-1:0] lim_rrd,
    output logic             spacing_ok
);
    localparam int AGE_W = CNT_W + 1;
    localparam logic [AGE_W-1:0] GAP_SAT = {AGE_W{1'b1}};

    logic [AGE_W-1:0] gap_q;
    logic             last_q;
    logic [AGE_W-1:0] e_rrd;

    // Gap since the most recent open grant on any bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= GAP_SAT;
        end else if (open_go) begin
            gap_q <= AGE_W'(1);
        end else if (gap_q != GAP_SAT) begin
            gap_q <= gap_q + AGE_W'(1);
        end
    end

    // Bank of the most recent open grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else if (open_go) begin
            last_q <= open_bank;
        end
    end

    // Permission: same bank needs no spacing, the other bank does.
    always_comb begin
        e_rrd      = (lim_rrd == '0) ? AGE_W'(1) : {1'b0, lim_rrd};
        spacing_ok = (ask_bank == last_q) || (gap_q >= e_rrd);
    end

endmodule

// File: rtl/bank_cmd_gate.sv
// Module: two-bank SDRAM command timing gate (top).
// Answers each requested command in the same cycle with grant or stall,
// based on per-bank trackers and a cross-bank open spacing tracker.
// Assumes the requester holds a stalled command and that write beats
// are reported on wr_last by the data path.
module bank_cmd_gate #(
    parameter int CNT_W     = 8,
    parameter int WARN_LEAD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_cmd,
    input  logic             req_bank,
    input  logic             wr_last,
    input  logic             wr_last_bank,
    input  logic [CNT_W-1:0] cfg_trcd,
    input  logic [CNT_W-1:0] cfg_trrd,
    input  logic [CNT_W-1:0] cfg_tras_min,
    input  logic [CNT_W-1:0] cfg_tras_max,
    input  logic [CNT_W-1:0] cfg_trp,
    input  logic [CNT_W-1:0] cfg_trdl,
    output logic             grant,
    output logic             stall,
    output logic [1:0]       bank_idle,
    output logic [1:0]       bank_active,
    output logic [1:0]       pchg_warn,
    output logic [1:0]       pchg_late
);
    import bank_cmd_pkg::*;

    cmd_e                 cmd;
    logic                 allow;
    logic                 spacing_ok;
    logic [NUM_BANKS-1:0] open_go;
    logic [NUM_BANKS-1:0] close_go;
    logic [NUM_BANKS-1:0] beat_hit;
    logic [NUM_BANKS-1:0] access_ok;
    logic [NUM_BANKS-1:0] close_ok;

    // Decode the request against the bank permissions.
    always_comb begin
        cmd = cmd_e'(req_cmd);
        unique case (cmd)
            CMD_NOP:                      allow = 1'b1;
            CMD_OPEN:                     allow = bank_idle[req_bank] && spacing_ok;
            CMD_READ, CMD_WRITE:          allow = access_ok[req_bank];
            CMD_CLOSE:                    allow = close_ok[req_bank];
            CMD_REFR, CMD_MSET, CMD_PDOWN: allow = &bank_idle;
            default:                      allow = 1'b0;
        endcase
        grant = req_valid && allow;
        stall = req_valid && !allow;
    end

    // One tracker per bank, fed with that bank's grant and write events.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_comb begin
            open_go[b]  = grant && (cmd == CMD_OPEN)  && (req_bank == 1'(b));
            close_go[b] = grant && (cmd == CMD_CLOSE) && (req_bank == 1'(b));
            beat_hit[b] = wr_last && (wr_last_bank == 1'(b));
        end

        bank_track #(
            .CNT_W     (CNT_W),
            .WARN_LEAD (WARN_LEAD)
        ) u_track (
            .clk         (clk),
            .rst_n       (rst_n),
            .open_go     (open_go[b]),
            .close_go    (close_go[b]),
            .wbeat_last  (beat_hit[b]),
            .lim_rcd     (cfg_trcd),
            .lim_ras_min (cfg_tras_min),
            .lim_ras_max (cfg_tras_max),
            .lim_rp      (cfg_trp),
            .lim_rdl     (cfg_trdl),
            .is_idle     (bank_idle[b]),
            .is_open     (bank_active[b]),
            .access_ok   (access_ok[b]),
            .close_ok    (close_ok[b]),
            .warn        (pchg_warn[b]),
            .late        (pchg_late[b])
        );
    end

    open_spacing #(
        .CNT_W (CNT_W)
    ) u_spacing (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_go    (|open_go),
        .open_bank  (req_bank),
        .ask_bank   (req_bank),
        .lim_rrd    (cfg_trrd),
        .spacing_ok (spacing_ok)
    );

endmodule

// File: rtl/bank_cmd_gate_chk.sv
// Module: assertion checker for the command timing gate, bound to the top.
module bank_cmd_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [2:0] req_cmd,
    input logic       req_bank,
    input logic       grant,
    input logic       stall,
    input logic [1:0] bank_idle,
    input logic [1:0] bank_active,
    input logic [1:0] pchg_warn,
    input logic [1:0] pchg_late
);
    // R10: a valid request gets exactly one answer
    p_one_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (grant != stall));

    // R10: no answer without a request
    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!grant && !stall));

    // R1: an open grant leaves bank 0 open next cycle
    p_open_b0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && req_cmd == 3'd1 && req_bank == 1'b0) |=> (bank_active[0] && !bank_idle[0]));

    // R1: an open grant leaves bank 1 open next cycle
    p_open_b1_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && req_cmd == 3'd1 && req_bank == 1'b1) |=> (bank_active[1] && !bank_idle[1]));

    // R6: a close grant ends the open phase next cycle
    p_close_b0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && req_cmd == 3'd4 && req_bank == 1'b0) |=> !bank_active[0]);

    p_close_b1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && req_cmd == 3'd4 && req_bank == 1'b1) |=> !bank_active[1]);

    // R2: accesses only reach an open bank
    p_access_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && (req_cmd == 3'd2 || req_cmd == 3'd3)) |-> bank_active[req_bank]);

    // R4: closes only reach an open bank
    p_close_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && req_cmd == 3'd4) |-> bank_active[req_bank]);

    // R7: device-wide commands need both banks idle
    p_all_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && req_cmd >= 3'd5) |-> (bank_idle == 2'b11));

    for (genvar b = 0; b < 2; b++) begin : g_flags
        // R5: overdue implies warned and open
        p_late_warn_r5: assert property (@(posedge clk) disable iff (!rst_n)
            pchg_late[b] |-> (pchg_warn[b] && bank_active[b]));

        // R1: a bank is never open and idle together
        p_phase_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !(bank_idle[b] && bank_active[b]));
    end
endmodule

bind bank_cmd_gate bank_cmd_gate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_cmd     (req_cmd),
    .req_bank    (req_bank),
    .grant       (grant),
    .stall       (stall),
    .bank_idle   (bank_idle),
    .bank_active (bank_active),
    .pchg_warn   (pchg_warn),
    .pchg_late   (pchg_late)
);

// File: tb/bank_cmd_gate_bench.sv
module bank_cmd_gate_bench;
    localparam int CW   = 5;
    localparam int LEAD = 3;
    localparam int BIG  = 1000000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_cmd = 3'd0;
    logic          req_bank = 1'b0;
    logic          wr_last = 1'b0;
    logic          wr_last_bank = 1'b0;
    logic [CW-1:0] cfg_trcd = '0, cfg_trrd = '0, cfg_tras_min = '0;
    logic [CW-1:0] cfg_tras_max = '0, cfg_trp = '0, cfg_trdl = '0;
    logic          grant, stall;
    logic [1:0]    bank_idle, bank_active, pchg_warn, pchg_late;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model state
    int st[2];
    int age[2];
    int wage[2];
    int gap;
    int lastb;

    always #10 clk = ~clk;

    bank_cmd_gate #(.CNT_W(CW), .WARN_LEAD(LEAD)) u_bank_cmd_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_bank(req_bank), .wr_last(wr_last), .wr_last_bank(wr_last_bank),
        .cfg_trcd(cfg_trcd), .cfg_trrd(cfg_trrd), .cfg_tras_min(cfg_tras_min),
        .cfg_tras_max(cfg_tras_max), .cfg_trp(cfg_trp), .cfg_trdl(cfg_trdl),
        .grant(grant), .stall(stall), .bank_idle(bank_idle),
        .bank_active(bank_active), .pchg_warn(pchg_warn), .pchg_late(pchg_late)
    );

    function automatic int e(input logic [CW-1:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    function automatic bit m_idle(input int b);
        return (st[b] == 0) || (st[b] == 2 && age[b] >= e(cfg_trp));
    endfunction

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd0: return "R10";
            3'd1: return "R1/R3";
            3'd2, 3'd3: return "R2";
            3'd4: return "R4/R8";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < 2; b++) begin
            st[b] = 0; age[b] = BIG; wage[b] = BIG;
        end
        gap = BIG; lastb = 0;
    endtask

    // one clock: drive, compare against model, advance model
    task automatic cycle(input bit v, input logic [2:0] c, input logic b,
                         input bit wl, input logic wlb, input string tag);
        bit ok;
        bit g;
        logic [1:0] ei, ea, ew, el;
        @(negedge clk);
        req_valid = v; req_cmd = c; req_bank = b; wr_last = wl; wr_last_bank = wlb;
        #2;
        case (c)
            3'd0: ok = 1;
            3'd1: ok = m_idle(b) && (int'(b) == lastb || gap >= e(cfg_trrd));
            3'd2, 3'd3: ok = (st[b] == 1) && (age[b] >= e(cfg_trcd));
            3'd4: ok = (st[b] == 1) && (age[b] >= e(cfg_tras_min)) &&
                       !(wl && wlb == b) && (wage[b] >= e(cfg_trdl));
            default: ok = m_idle(0) && m_idle(1);
        endcase
        g = v && ok;
        for (int k = 0; k < 2; k++) begin
            ei[k] = m_idle(k);
            ea[k] = (st[k] == 1);
            ew[k] = (st[k] == 1) && (age[k] + LEAD >= e(cfg_tras_max));
            el[k] = (st[k] == 1) && (age[k] > e(cfg_tras_max));
        end
        chk((tag == "") ? tag_of(c) : tag, "grant", grant, g);
        chk("R10", "stall", stall, v && !ok);
        chk("R6", "bank_idle", bank_idle, ei);
        chk("R1", "bank_active", bank_active, ea);
        chk("R5", "pchg_warn", pchg_warn, ew);
        chk("R5", "pchg_late", pchg_late, el);
        @(posedge clk);
        for (int k = 0; k < 2; k++) begin
            if (age[k] < BIG) age[k]++;
            if (wage[k] < BIG) wage[k]++;
        end
        if (gap < BIG) gap++;
        if (wl) wage[wlb] = 1;
        if (g && c == 3'd1) begin st[b] = 1; age[b] = 1; gap = 1; lastb = b; end
        if (g && c == 3'd4) begin st[b] = 2; age[b] = 1; end
    endtask

    task automatic set_cfg(input int rcd, input int rrd, input int rmin,
                           input int rmax, input int rp, input int rdl);
        cfg_trcd = CW'(rcd); cfg_trrd = CW'(rrd); cfg_tras_min = CW'(rmin);
        cfg_tras_max = CW'(rmax); cfg_trp = CW'(rp); cfg_trdl = CW'(rdl);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; wr_last = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // watchdog
    initial begin
        #(200000 * 20);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        set_cfg(3, 2, 5, 12, 3, 2);
        do_reset();
        // R11: reset state and an immediate device-wide command
        #1;
        chk("R11", "bank_idle after reset", bank_idle, 2'b11);
        chk("R11", "bank_active after reset", bank_active, 2'b00);
        chk("R11", "flags after reset", {pchg_warn, pchg_late}, 0);
        cycle(1, 3'd5, 0, 0, 0, "R11");
        cycle(0, 3'd0, 0, 0, 0, "R10");
        // R1, R3: open b0, then b1 too early and after spacing
        cycle(1, 3'd1, 0, 0, 0, "R1");
        cycle(1, 3'd1, 1, 0, 0, "R3");
        cycle(1, 3'd1, 1, 0, 0, "R3");
        cycle(1, 3'd1, 0, 0, 0, "R1");
        // R2: read b0 at the tRCD edge
        for (int i = 0; i < 3; i++) cycle(1, 3'd2, 0, 0, 0, "R2");
        // R7: refresh while open must stall
        cycle(1, 3'd5, 0, 0, 0, "R7");
        // R8: write beat then close races
        cycle(1, 3'd3, 0, 1, 0, "R8");
        cycle(1, 3'd4, 0, 1, 0, "R8");
        for (int i = 0; i < 3; i++) cycle(1, 3'd4, 0, 0, 0, "R4");
        // R6: reopen until idle after tRP
        for (int i = 0; i < 4; i++) cycle(1, 3'd1, 0, 0, 0, "R6");
        // R5: let bank 1 overstay its window
        for (int i = 0; i < 14; i++) cycle(0, 3'd0, 0, 0, 0, "R5");
        // R9: all limits zero
        do_reset();
        set_cfg(0, 0, 0, 0, 0, 0);
        cycle(1, 3'd1, 0, 0, 0, "R9");
        cycle(1, 3'd2, 0, 0, 0, "R9");
        cycle(1, 3'd1, 1, 0, 0, "R9");
        cycle(1, 3'd4, 0, 0, 0, "R9");
        cycle(1, 3'd1, 0, 0, 0, "R9");
        cycle(1, 3'd4, 1, 1, 1, "R9");
        cycle(1, 3'd4, 1, 0, 0, "R9");
        cycle(0, 3'd0, 0, 0, 0, "R9");
        // random streams under several limit sets
        for (int s = 0; s < 5; s++) begin
            case (s)
                0: set_cfg(2, 3, 4, 10, 2, 1);
                1: set_cfg(0, 1, 0, 3, 0, 4);
                2: set_cfg(5, 4, 8, 31, 6, 3);
                3: set_cfg(1, 0, 2, 6, 1, 0);
                default: set_cfg(7, 7, 9, 14, 4, 5);
            endcase
            for (int i = 0; i < 1500; i++) begin
                cycle($urandom_range(0, 9) != 0, 3'($urandom_range(0, 7)),
                      1'($urandom_range(0, 1)), $urandom_range(0, 7) == 0,
                      1'($urandom_range(0, 1)), "");
            end
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule